// File: doc/BRIEF.md
# I2C Single-Command Transaction Engine

This block is an I2C master sequencer driven by one command word. Software loads an optional 40-bit extension word and then a 64-bit command word with its valid bit set. The engine then runs a complete bus transaction without further help. The transaction is START, target address, an optional one- or two-byte internal address, one to eight data bytes, and STOP. Four transaction kinds are supported: plain read, plain write, internal-address write followed by a repeated-START read, and internal-address write followed by data.

Bit-level SCL/SDA timing lives in a separate bit engine. The two blocks talk through a byte-level request/done handshake: the sequencer holds a request with an operation code, and the bit engine answers with a one-cycle done pulse. The outcome is written back into the command word. The valid bit falls when the transaction ends, and a result bit reads 1 on success. On failure the result bit reads 0 and the low byte of the command word holds a bus status code. Read data is returned in the data lanes of the command and extension words.

Top module: `i2c_cmd_engine`

## Requirements
- R1: Command word bit 63 is the valid bit. Writing the command word with bit 63 set, while the engine is idle, starts a transaction. The engine clears bit 63 when the transaction ends. A write with bit 63 clear only stores the word.
- R2: Command bits 54:52 hold the data byte count minus one. Exactly that many plus one data bytes are transferred, so counts of 1 to 8 are possible.
- R3: Data byte k of an n-byte message has reverse index r = n-1-k. For r < 4 the byte sits in command bits [8r+7:8r]. Otherwise it sits in extension bits [8(r-4)+7:8(r-4)]. So the final byte always takes the lowest lane of the command word.
- R4: Command bits 46:40 hold the 7-bit target address. The address byte on the bus is {address, R/W}, with R/W = 1 for reads.
- R5: Bit-engine operation codes are 0 = START, 1 = repeated START, 2 = write byte, 3 = read byte, 4 = STOP. A plain transfer (bit 57 = 0) is START, address, data, STOP. Every transaction ends with a STOP.
- R6: When bit 57 is set, the internal address byte in command bits 39:32 is written after the address. When bit 56 is also set, extension bits 39:32 are written before it as the first internal-address byte.
- R7: Command bit 62 selects a read. A combined read follows the internal address with a repeated START, an address byte with R/W = 1, and the reads. A combined write sends the data bytes straight after the internal address.
- R8: On reads, the master-acknowledge output is 1 for every data byte except the final one, where it is 0 (NAK).
- R9: On success, bit 62 reads back as 1 and read data is stored in the lanes of R3.
- R10: A NAK on an address or written byte aborts the transfer with STOP, and no further bytes are sent. Bit 62 is then cleared and bits 7:0 hold the status code. The codes are 0x20 for a write-address NAK, 0x48 for a read-address NAK and 0x30 for a written-byte NAK. Bits 31:8 are left unchanged.
- R11: The completion interrupt is a one-cycle pulse in the cycle the valid bit reads low after a transaction, once per transaction.
- R12: While the valid bit is set, writes to the command word and to the extension word are ignored.
- R13: After reset both words read zero, and the request and interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 64 | Command word write data |
| ext_wr | input | 1 | Write strobe for the extension word |
| ext_wdata | input | 40 | Extension word write data |
| cmd_rdata | output | 64 | Current command word, including results |
| ext_rdata | output | 40 | Current extension word, including read data |
| done_irq | output | 1 | One-cycle completion pulse |
| be_req | output | 1 | Request to the bit engine, held until done |
| be_op | output | 3 | Bit-engine operation code |
| be_wbyte | output | 8 | Byte to transmit on write operations |
| be_mack | output | 1 | Master acknowledges the byte on read operations |
| be_done | input | 1 | Bit engine completed the requested operation |
| be_rbyte | input | 8 | Byte received on read operations |
| be_nak | input | 1 | Slave answered NAK on a write operation |

## Verification
A wrong sequencer state shows up first on the bit-engine interface, within the done pulse of the faulty step. The symptoms there are a missing repeated START, a byte out of order, a misplaced master NAK, or traffic continuing after a slave NAK. A wrong byte counter or lane index instead corrupts the returned data lanes. That corruption is visible in the command and extension words as soon as the valid bit falls. Mishandled completion shows as a result bit, status byte or interrupt count that disagrees with the bus log on the same cycle the valid bit drops.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
    localparam int CMD_W      = 64;
    localparam int EXT_W      = 40;
    localparam int DATA_LANES = 4;
    localparam int IDX_W      = $clog2(2 * DATA_LANES);
    localparam int LANE_BITS  = 8 * DATA_LANES;

    localparam int VALID_B  = 63;
    localparam int RES_B    = 62;
    localparam int COMB_B   = 57;
    localparam int EIA_B    = 56;
    localparam int SIZE_LSB = 52;
    localparam int ADDR_LSB = 40;
    localparam int IA_LSB   = 32;

    typedef enum logic [2:0] {
        BE_START  = 3'd0,
        BE_RSTART = 3'd1,
        BE_WRITE  = 3'd2,
        BE_READ   = 3'd3,
        BE_STOP   = 3'd4
    } be_op_t;

    typedef enum logic [3:0] {
        S_IDLE, S_START, S_ADDR, S_IA_HI, S_IA_LO,
        S_RSTART, S_RADDR, S_WDATA, S_RDATA, S_STOP
    } seq_state_t;
endpackage

// File: rtl/i2c_cmd_lane_pick.sv
module i2c_cmd_lane_pick import i2c_cmd_pkg::*; (
    input  logic [LANE_BITS-1:0] main_lanes,
    input  logic [LANE_BITS-1:0] ext_lanes,
    input  logic [IDX_W-1:0]     rev,
    output logic [7:0]           byte_o
);
    localparam int N = 2 * DATA_LANES;
    logic [7:0] all_bytes [N];

    for (genvar i = 0; i < N; i++) begin : g_lane
        if (i < DATA_LANES) begin : g_main
            assign all_bytes[i] = main_lanes[8*i +: 8];
        end else begin : g_ext
            assign all_bytes[i] = ext_lanes[8*(i-DATA_LANES) +: 8];
        end
    end

    assign byte_o = all_bytes[rev];
endmodule

// File: rtl/i2c_cmd_lane_place.sv
module i2c_cmd_lane_place import i2c_cmd_pkg::*; (
    input  logic [LANE_BITS-1:0] main_lanes,
    input  logic [LANE_BITS-1:0] ext_lanes,
    input  logic [IDX_W-1:0]     rev,
    input  logic [7:0]           byte_i,
    output logic [LANE_BITS-1:0] main_o,
    output logic [LANE_BITS-1:0] ext_o
);
    for (genvar i = 0; i < DATA_LANES; i++) begin : g_lane
        assign main_o[8*i +: 8] = (rev == IDX_W'(i))
                                ? byte_i : main_lanes[8*i +: 8];
        assign ext_o[8*i +: 8]  = (rev == IDX_W'(i + DATA_LANES))
                                ? byte_i : ext_lanes[8*i +: 8];
    end
endmodule

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine import i2c_cmd_pkg::*; #(
    parameter logic [7:0] STAT_AW_NAK = 8'h20,
    parameter logic [7:0] STAT_AR_NAK = 8'h48,
    parameter logic [7:0] STAT_D_NAK  = 8'h30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_wdata,
    input  logic             ext_wr,
    input  logic [EXT_W-1:0] ext_wdata,
    output logic [CMD_W-1:0] cmd_rdata,
    output logic [EXT_W-1:0] ext_rdata,
    output logic             done_irq,
    output logic             be_req,
    output logic [2:0]       be_op,
    output logic [7:0]       be_wbyte,
    output logic             be_mack,
    input  logic             be_done,
    input  logic [7:0]       be_rbyte,
    input  logic             be_nak
);
    typedef struct packed {
        seq_state_t       st;
        logic [CMD_W-1:0] cmd;
        logic [EXT_W-1:0] ext;
        logic [IDX_W-1:0] idx;
        logic             fail;
        logic [7:0]       code;
        logic             irq;
    } regs_t;

    regs_t r_q, r_d;

    logic             f_rd, f_comb, f_eia, last;
    logic [IDX_W-1:0] f_size, rev;
    logic [6:0]       f_addr;
    logic [7:0]       pick_byte;
    logic [LANE_BITS-1:0] pl_main, pl_ext;
    be_op_t           op;

    assign f_rd   = r_q.cmd[RES_B];
    assign f_comb = r_q.cmd[COMB_B];
    assign f_eia  = r_q.cmd[EIA_B];
    assign f_size = r_q.cmd[SIZE_LSB +: IDX_W];
    assign f_addr = r_q.cmd[ADDR_LSB +: 7];
    assign last   = (r_q.idx == f_size);
    assign rev    = f_size - r_q.idx;

    i2c_cmd_lane_pick u_pick (
        .main_lanes (r_q.cmd[LANE_BITS-1:0]),
        .ext_lanes  (r_q.ext[LANE_BITS-1:0]),
        .rev        (rev),
        .byte_o     (pick_byte)
    );

    i2c_cmd_lane_place u_place (
        .main_lanes (r_q.cmd[LANE_BITS-1:0]),
        .ext_lanes  (r_q.ext[LANE_BITS-1:0]),
        .rev        (rev),
        .byte_i     (be_rbyte),
        .main_o     (pl_main),
        .ext_o      (pl_ext)
    );

    always_comb begin
        r_d     = r_q;
        r_d.irq = 1'b0;
        case (r_q.st)
            S_IDLE: begin
                if (ext_wr) r_d.ext = ext_wdata;
                if (cmd_wr) begin
                    r_d.cmd = cmd_wdata;
                    if (cmd_wdata[VALID_B]) begin
                        r_d.st   = S_START;
                        r_d.fail = 1'b0;
                        r_d.code = 8'h00;
                    end
                end
            end
            S_START:  if (be_done) r_d.st = S_ADDR;
            S_ADDR: if (be_done) begin
                r_d.idx = '0;
                if (be_nak) begin
                    r_d.fail = 1'b1;
                    r_d.code = (f_rd && !f_comb) ? STAT_AR_NAK : STAT_AW_NAK;
                    r_d.st   = S_STOP;
                end else if (f_comb) begin
                    r_d.st = f_eia ? S_IA_HI : S_IA_LO;
                end else begin
                    r_d.st = f_rd ? S_RDATA : S_WDATA;
                end
            end
            S_IA_HI: if (be_done) begin
                if (be_nak) begin
                    r_d.fail = 1'b1;
                    r_d.code = STAT_D_NAK;
                    r_d.st   = S_STOP;
                end else begin
                    r_d.st = S_IA_LO;
                end
            end
            S_IA_LO: if (be_done) begin
                if (be_nak) begin
                    r_d.fail = 1'b1;
                    r_d.code = STAT_D_NAK;
                    r_d.st   = S_STOP;
                end else begin
                    r_d.st = f_rd ? S_RSTART : S_WDATA;
                end
            end
            S_RSTART: if (be_done) r_d.st = S_RADDR;
            S_RADDR: if (be_done) begin
                if (be_nak) begin
                    r_d.fail = 1'b1;
                    r_d.code = STAT_AR_NAK;
                    r_d.st   = S_STOP;
                end else begin
                    r_d.st = S_RDATA;
                end
            end
            S_WDATA: if (be_done) begin
                if (be_nak) begin
                    r_d.fail = 1'b1;
                    r_d.code = STAT_D_NAK;
                    r_d.st   = S_STOP;
                end else if (last) begin
                    r_d.st = S_STOP;
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                end
            end
            S_RDATA: if (be_done) begin
                r_d.cmd[LANE_BITS-1:0] = pl_main;
                r_d.ext[LANE_BITS-1:0] = pl_ext;
                if (last) r_d.st  = S_STOP;
                else      r_d.idx = r_q.idx + 1'b1;
            end
            S_STOP: if (be_done) begin
                r_d.st           = S_IDLE;
                r_d.cmd[VALID_B] = 1'b0;
                r_d.cmd[RES_B]   = !r_q.fail;
                if (r_q.fail) r_d.cmd[7:0] = r_q.code;
                r_d.irq          = 1'b1;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: S_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        op       = BE_STOP;
        be_wbyte = 8'h00;
        case (r_q.st)
            S_START:  op = BE_START;
            S_RSTART: op = BE_RSTART;
            S_ADDR:   begin op = BE_WRITE; be_wbyte = {f_addr, f_rd && !f_comb}; end
            S_RADDR:  begin op = BE_WRITE; be_wbyte = {f_addr, 1'b1}; end
            S_IA_HI:  begin op = BE_WRITE; be_wbyte = r_q.ext[IA_LSB +: 8]; end
            S_IA_LO:  begin op = BE_WRITE; be_wbyte = r_q.cmd[IA_LSB +: 8]; end
            S_WDATA:  begin op = BE_WRITE; be_wbyte = pick_byte; end
            S_RDATA:  op = BE_READ;
            default:  op = BE_STOP;
        endcase
    end

    assign be_op     = op;
    assign be_req    = (r_q.st != S_IDLE);
    assign be_mack   = (r_q.st == S_RDATA) && !last;
    assign cmd_rdata = r_q.cmd;
    assign ext_rdata = r_q.ext;
    assign done_irq  = r_q.irq;

    AST_IRQ_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_rdata[VALID_B]) |-> done_irq) else $error("irq missing"); // R11
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq) else $error("irq longer than one cycle"); // R11
    AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        be_req |-> cmd_rdata[VALID_B]) else $error("request while idle"); // R1
    AST_END_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_rdata[VALID_B]) |-> ($past(be_op) == BE_STOP) && $past(be_done))
        else $error("ended without STOP"); // R5
    AST_BUSY_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && cmd_rdata[VALID_B] |=> $stable(cmd_rdata[ADDR_LSB +: 7]))
        else $error("busy write took effect"); // R12
    AST_FAIL_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_rdata[VALID_B]) && !cmd_rdata[RES_B] |-> cmd_rdata[7:0] != 8'h00)
        else $error("failure without code"); // R10
endmodule

// File: tb/tb_i2c_cmd_engine.sv
module tb_i2c_cmd_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0, ext_wr = 1'b0;
    logic [63:0] cmd_wdata = '0;
    logic [39:0] ext_wdata = '0;
    logic [63:0] cmd_rdata;
    logic [39:0] ext_rdata;
    logic        done_irq, be_req, be_mack;
    logic [2:0]  be_op;
    logic [7:0]  be_wbyte;
    logic        be_done = 1'b0, be_nak = 1'b0;
    logic [7:0]  be_rbyte = '0;

    always #10 clk = ~clk;

    i2c_cmd_engine dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .ext_wr(ext_wr), .ext_wdata(ext_wdata), .cmd_rdata(cmd_rdata),
        .ext_rdata(ext_rdata), .done_irq(done_irq), .be_req(be_req),
        .be_op(be_op), .be_wbyte(be_wbyte), .be_mack(be_mack),
        .be_done(be_done), .be_rbyte(be_rbyte), .be_nak(be_nak)
    );

    int checks = 0, fails = 0, irq_cnt = 0;
    int nlog = 0, rd_cnt = 0;
    logic [2:0] op_log [64];
    logic [7:0] by_log [64];
    logic       mk_log [64];
    logic [2:0] e_op [64];
    logic [7:0] e_by [64];
    logic       e_mk [64];
    int         en = 0;

    // slave / bit-engine model: target 0x50 acks; byte 0xEE is refused
    initial begin : bit_model
        logic first_after_start;
        first_after_start = 1'b0;
        forever begin
            @(negedge clk);
            if (be_req) begin
                if (nlog < 64) begin
                    op_log[nlog] = be_op; by_log[nlog] = be_wbyte; mk_log[nlog] = be_mack;
                end
                nlog++;
                be_nak = 1'b0;
                if (be_op == 3'd0 || be_op == 3'd1) first_after_start = 1'b1;
                else if (be_op == 3'd2) begin
                    if (first_after_start) be_nak = (be_wbyte[7:1] != 7'h50);
                    else be_nak = (be_wbyte == 8'hEE);
                    first_after_start = 1'b0;
                end else if (be_op == 3'd3) begin
                    be_rbyte = 8'hA0 + 8'(rd_cnt);
                    rd_cnt++;
                end
                @(negedge clk);
                be_done = 1'b1;
                @(negedge clk);
                be_done = 1'b0;
                be_nak = 1'b0;
            end
        end
    end

    always @(negedge clk) if (done_irq) irq_cnt++;

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired act=hung exp=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(bit rd, bit comb, bit eia, logic [2:0] sz,
                                      logic [6:0] ad, logic [7:0] ia, logic [31:0] d);
        return {1'b1, rd, 4'b0, comb, eia, 1'b0, sz, 5'b0, ad, ia, d};
    endfunction

    task automatic ex(input logic [2:0] o, input logic [7:0] b, input logic m);
        e_op[en] = o; e_by[en] = b; e_mk[en] = m; en++;
    endtask

    task automatic cmp_log(input string tag);
        chk(nlog == en, {tag, " op count"}, 64'(nlog), 64'(en));
        for (int i = 0; i < en && i < nlog; i++) begin
            chk(op_log[i] == e_op[i], {tag, " op"}, 64'(op_log[i]), 64'(e_op[i]));
            if (e_op[i] == 3'd2)
                chk(by_log[i] == e_by[i], {tag, " byte"}, 64'(by_log[i]), 64'(e_by[i]));
            if (e_op[i] == 3'd3)
                chk(mk_log[i] == e_mk[i], {tag, " R8 mack"}, 64'(mk_log[i]), 64'(e_mk[i]));
        end
    endtask

    task automatic run(input logic [63:0] c, input logic [39:0] e);
        nlog = 0; en = 0; rd_cnt = 0; irq_cnt = 0;
        @(negedge clk); ext_wr = 1'b1; ext_wdata = e;
        @(negedge clk); ext_wr = 1'b0; cmd_wr = 1'b1; cmd_wdata = c;
        @(negedge clk); cmd_wr = 1'b0;
        for (int i = 0; i < 2000 && cmd_rdata[63]; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(cmd_rdata == 64'h0, "R13 cmd reset", cmd_rdata, 64'h0);
        chk(ext_rdata == 40'h0, "R13 ext reset", 64'(ext_rdata), 64'h0);
        chk(!be_req && !done_irq, "R13 outputs low", {62'h0, be_req, done_irq}, 64'h0);
    endtask

    task automatic t_write3();
        run(mk(0, 0, 0, 3'd2, 7'h50, 8'h00, 32'h00112233), 40'h0);
        ex(0, 0, 0); ex(2, 8'hA0, 0); ex(2, 8'h11, 0); ex(2, 8'h22, 0); ex(2, 8'h33, 0); ex(4, 0, 0);
        cmp_log("R2 R4 R5 write3");
        chk(!cmd_rdata[63], "R1 valid cleared", 64'(cmd_rdata[63]), 64'h0);
        chk(cmd_rdata[62], "R9 result set", 64'(cmd_rdata[62]), 64'h1);
        chk(irq_cnt == 1, "R11 one irq", 64'(irq_cnt), 64'h1);
    endtask

    task automatic t_write6();
        // bytes b0..b5 = 01..06: b5..b2 in cmd lanes 0..3, b1 b0 in ext lanes 0,1
        run(mk(0, 0, 0, 3'd5, 7'h50, 8'h00, 32'h03040506), 40'h00_0000_0102);
        ex(0, 0, 0); ex(2, 8'hA0, 0);
        for (int k = 1; k <= 6; k++) ex(2, 8'(k), 0);
        ex(4, 0, 0);
        cmp_log("R3 write6 lanes");
        chk(cmd_rdata[62], "R9 write6 result", 64'(cmd_rdata[62]), 64'h1);
    endtask

    task automatic t_read2();
        run(mk(1, 0, 0, 3'd1, 7'h50, 8'h00, 32'h0), 40'h0);
        ex(0, 0, 0); ex(2, 8'hA1, 0); ex(3, 0, 1); ex(3, 0, 0); ex(4, 0, 0);
        cmp_log("R4 R8 read2");
        chk(cmd_rdata[15:0] == 16'hA0A1, "R3 R9 read2 data", 64'(cmd_rdata[15:0]), 64'hA0A1);
        chk(cmd_rdata[62], "R9 read2 result", 64'(cmd_rdata[62]), 64'h1);
    endtask

    task automatic t_read8();
        run(mk(1, 0, 0, 3'd7, 7'h50, 8'h00, 32'h0), 40'h0);
        ex(0, 0, 0); ex(2, 8'hA1, 0);
        for (int k = 0; k < 8; k++) ex(3, 0, k != 7);
        ex(4, 0, 0);
        cmp_log("R2 R8 read8");
        chk(cmd_rdata[31:0] == 32'hA4A5A6A7, "R3 read8 main", 64'(cmd_rdata[31:0]), 64'hA4A5A6A7);
        chk(ext_rdata[31:0] == 32'hA0A1A2A3, "R3 read8 ext", 64'(ext_rdata[31:0]), 64'hA0A1A2A3);
    endtask

    task automatic t_comb_read();
        run(mk(1, 1, 1, 3'd0, 7'h50, 8'h34, 32'h0), 40'h12_0000_0000);
        ex(0, 0, 0); ex(2, 8'hA0, 0); ex(2, 8'h12, 0); ex(2, 8'h34, 0);
        ex(1, 0, 0); ex(2, 8'hA1, 0); ex(3, 0, 0); ex(4, 0, 0);
        cmp_log("R6 R7 comb read");
        chk(cmd_rdata[7:0] == 8'hA0 && cmd_rdata[62], "R7 comb read data", cmd_rdata[63:0], 64'hA0);
    endtask

    task automatic t_comb_write();
        run(mk(0, 1, 0, 3'd1, 7'h50, 8'h34, 32'h00005566), 40'h99_0000_0000);
        ex(0, 0, 0); ex(2, 8'hA0, 0); ex(2, 8'h34, 0); ex(2, 8'h55, 0); ex(2, 8'h66, 0); ex(4, 0, 0);
        cmp_log("R6 R7 comb write");
        chk(cmd_rdata[62], "R9 comb write result", 64'(cmd_rdata[62]), 64'h1);
    endtask

    task automatic t_nak();
        run(mk(0, 0, 0, 3'd1, 7'h51, 8'h00, 32'h0000ABCD), 40'h0);
        ex(0, 0, 0); ex(2, 8'hA2, 0); ex(4, 0, 0);
        cmp_log("R10 addr nak write");
        chk(cmd_rdata[7:0] == 8'h20 && !cmd_rdata[62], "R10 code 20",
            {cmd_rdata[62], cmd_rdata[7:0]}, 64'h020);
        chk(cmd_rdata[15:8] == 8'hAB, "R10 upper data kept", 64'(cmd_rdata[15:8]), 64'hAB);
        run(mk(1, 0, 0, 3'd0, 7'h51, 8'h00, 32'h0), 40'h0);
        chk(cmd_rdata[7:0] == 8'h48 && !cmd_rdata[62], "R10 code 48",
            {cmd_rdata[62], cmd_rdata[7:0]}, 64'h048);
        run(mk(0, 0, 0, 3'd2, 7'h50, 8'h00, 32'h00EE07), 40'h0);
        ex(0, 0, 0); ex(2, 8'hA0, 0); ex(2, 8'h00, 0); ex(2, 8'hEE, 0); ex(4, 0, 0);
        cmp_log("R10 data nak");
        chk(cmd_rdata[7:0] == 8'h30 && !cmd_rdata[62], "R10 code 30",
            {cmd_rdata[62], cmd_rdata[7:0]}, 64'h030);
        chk(irq_cnt == 1, "R11 irq on failure", 64'(irq_cnt), 64'h1);
    endtask

    task automatic t_busy();
        nlog = 0; en = 0; rd_cnt = 0; irq_cnt = 0;
        @(negedge clk); ext_wr = 1'b1; ext_wdata = 40'h00_0000_0000;
        @(negedge clk); ext_wr = 1'b0; cmd_wr = 1'b1;
        cmd_wdata = mk(0, 0, 0, 3'd0, 7'h50, 8'h00, 32'h0000_0042);
        @(negedge clk); cmd_wr = 1'b0;
        repeat (2) @(negedge clk);
        cmd_wr = 1'b1; ext_wr = 1'b1;
        cmd_wdata = mk(0, 0, 0, 3'd0, 7'h33, 8'h00, 32'h0000_0077);
        ext_wdata = 40'hFF_FFFF_FFFF;
        @(negedge clk); cmd_wr = 1'b0; ext_wr = 1'b0;
        for (int i = 0; i < 2000 && cmd_rdata[63]; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        ex(0, 0, 0); ex(2, 8'hA0, 0); ex(2, 8'h42, 0); ex(4, 0, 0);
        cmp_log("R12 busy write ignored");
        chk(cmd_rdata[46:40] == 7'h50, "R12 addr kept", 64'(cmd_rdata[46:40]), 64'h50);
        chk(ext_rdata == 40'h0, "R12 ext kept", 64'(ext_rdata), 64'h0);
        // a store with valid clear does not start anything
        nlog = 0;
        @(negedge clk); cmd_wr = 1'b1; cmd_wdata = 64'h0000_0000_0000_1234;
        @(negedge clk); cmd_wr = 1'b0;
        repeat (10) @(negedge clk);
        chk(nlog == 0 && cmd_rdata == 64'h1234, "R1 store only", cmd_rdata, 64'h1234);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_write3();
        t_write6();
        t_read2();
        t_read8();
        t_comb_read();
        t_comb_write();
        t_nak();
        t_busy();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule